// File: doc/BRIEF.md
# Serial Memory Status Register and Write-Protect Guard

This block keeps the status register of a serial memory device and rules on every command that could modify the device. Its state is the write-enable latch, a two-bit block-protect field, a protect-enable bit that arms the external write-protect pin, and a busy flag. The busy flag is held high by a self-timed cycle counter for as long as a program, erase or status-register update is in progress.

The command decoder in front of it raises a one-cycle strobe when a command has been fully received. The strobe carries an operation code, a target byte address and, for a status write, the data byte. One cycle later the block answers with exactly one of accept or abort. Accepted modifying commands start the matching self-timed cycle. The status byte is always presented for a status-read path to shift out.

Top module: `nvm_status_guard`

## Requirements
- R1: The status byte is {protect-enable (bit 7), three zero bits (6:4), block-protect high (bit 3), block-protect low (bit 2), write-enable latch (bit 1), busy (bit 0)}. After reset it reads 00h, and bits 6:4 read 0 whatever was written.
- R2: Operation code 0 sets the write-enable latch and code 1 clears it. Both are accepted whenever the block is idle, whatever the pin level or the protect-enable bit.
- R3: Codes 2 (status write), 3 (program), 4 (page erase), 5 (sector erase) and 6 (chip erase) are aborted when the write-enable latch is 0.
- R4: A status write is aborted when protect-enable is 1 and the pin is low. Otherwise, with the latch set, it is accepted and loads protect-enable from data bit 7 and the block-protect field from data bits 3:2.
- R5: Codes 3, 4 and 5 are aborted when the address falls in the protected region. Block-protect 01 locks the top quarter of the address space, 10 locks the top half, 11 locks everything and 00 locks nothing.
- R6: Chip erase is accepted only when both block-protect bits are 0.
- R7: An accepted modifying command holds busy high for exactly T_WRITE cycles (codes 2, 3, 4), T_SECT cycles (code 5) or T_CHIP cycles (code 6).
- R8: The write-enable latch stays set during a cycle and clears when the cycle ends. An aborted command leaves the latch unchanged.
- R9: Any command that arrives while busy is high is aborted and changes nothing.
- R10: A new status-register value becomes visible when its cycle ends. A pin change during that cycle has no effect on it.
- R11: In the cycle after each strobe, exactly one of accept and abort is high. Neither is high in any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command-complete strobe |
| cmd_op | input | 3 | Operation code (0..6) |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_wdata | input | 8 | Data byte for a status write |
| wp_pin | input | 1 | Write-protect pin level (1 = high) |
| status_byte | output | 8 | Current status byte |
| cmd_accept | output | 1 | Command accepted, one cycle after strobe |
| cmd_abort | output | 1 | Command refused, one cycle after strobe |
| wip | output | 1 | Self-timed cycle in progress |

## Verification
Array commands are aimed at the addresses on each side of the quarter and half boundaries under every block-protect setting. An off-by-one in the region decode therefore shows up as a wrong accept or abort. Status writes are issued with the pin high and low, and with protect-enable both set and clear, which separates the lock condition from the latch condition. The pin is also moved during a running cycle. Busy windows are measured for all three cycle lengths. Commands sent into a busy window show that nothing leaks through while a cycle runs.

// File: rtl/nvm_status_pkg.sv
package nvm_status_pkg;
   typedef enum logic [2:0] {
      OP_WEN_SET    = 3'd0,
      OP_WEN_CLR    = 3'd1,
      OP_SR_WRITE   = 3'd2,
      OP_PROGRAM    = 3'd3,
      OP_PAGE_ERASE = 3'd4,
      OP_SECT_ERASE = 3'd5,
      OP_CHIP_ERASE = 3'd6
   } nvm_op_e;

   typedef enum logic [1:0] {
      CYC_WRITE = 2'd0,
      CYC_SECT  = 2'd1,
      CYC_CHIP  = 2'd2
   } cyc_kind_e;

   localparam int SR_PROT_EN = 7;
   localparam int SR_BP_HI   = 3;
   localparam int SR_BP_LO   = 2;
endpackage

// File: rtl/nvm_prot_decode.sv
module nvm_prot_decode #(
   parameter int ADDR_W = 17
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              addr_locked,
   output logic              any_locked
);
   localparam int NQ = 4;

   if (ADDR_W < 2) begin : g_bad_width
      $error("nvm_prot_decode: ADDR_W must be at least 2");
   end

   logic [NQ-1:0] q_mask;
   logic [1:0]    quarter;

   for (genvar gq = 0; gq < NQ; gq++) begin : g_quarter
      assign q_mask[gq] = (bp == 2'b11)
                        | ((bp == 2'b10) & (gq >= 2))
                        | ((bp == 2'b01) & (gq == NQ - 1));
   end

   assign quarter     = addr[ADDR_W-1 -: 2];
   assign addr_locked = q_mask[quarter];
   assign any_locked  = |bp;
endmodule

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer
   import nvm_status_pkg::*;
#(
   parameter int T_WRITE = 1250000,
   parameter int T_SECT  = 500000000,
   parameter int T_CHIP  = 1000000000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  cyc_kind_e kind,
   output logic      busy,
   output logic      done
);
   localparam int T_MAX0 = (T_WRITE > T_SECT) ? T_WRITE : T_SECT;
   localparam int T_MAX  = (T_MAX0 > T_CHIP) ? T_MAX0 : T_CHIP;
   localparam int CNT_W  = $clog2(T_MAX + 1);

   if (T_WRITE < 1 || T_SECT < 1 || T_CHIP < 1) begin : g_bad_time
      $error("nvm_cycle_timer: every cycle length must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      unique case (kind)
         CYC_SECT: load_val = CNT_W'(T_SECT - 1);
         CYC_CHIP: load_val = CNT_W'(T_CHIP - 1);
         default:  load_val = CNT_W'(T_WRITE - 1);
      endcase
   end

   assign done = busy & (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= load_val;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   // R9: a cycle is never restarted while one runs
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R7: the count always walks down toward the end of the cycle
   a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !start) |=> (busy && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
   import nvm_status_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int T_WRITE = 1250000,
   parameter int T_SECT  = 500000000,
   parameter int T_CHIP  = 1000000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_wdata,
   input  logic              wp_pin,
   output logic [7:0]        status_byte,
   output logic              cmd_accept,
   output logic              cmd_abort,
   output logic              wip
);
   nvm_op_e   op;
   cyc_kind_e kind;
   logic      wel, prot_en;
   logic [1:0] bp;
   logic      pend_sr, pend_prot_en;
   logic [1:0] pend_bp;
   logic      addr_locked, any_locked, sr_locked;
   logic      rule_ok, allow, start, done;

   assign op = nvm_op_e'(cmd_op);

   nvm_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bp          (bp),
      .addr        (cmd_addr),
      .addr_locked (addr_locked),
      .any_locked  (any_locked)
   );

   nvm_cycle_timer #(.T_WRITE(T_WRITE), .T_SECT(T_SECT), .T_CHIP(T_CHIP)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .kind  (kind),
      .busy  (wip),
      .done  (done)
   );

   assign sr_locked = prot_en & ~wp_pin;

   always_comb begin
      kind = CYC_WRITE;
      unique case (op)
         OP_WEN_SET, OP_WEN_CLR:               rule_ok = 1'b1;
         OP_SR_WRITE:                          rule_ok = wel & ~sr_locked;
         OP_PROGRAM, OP_PAGE_ERASE:            rule_ok = wel & ~addr_locked;
         OP_SECT_ERASE: begin
            rule_ok = wel & ~addr_locked;
            kind    = CYC_SECT;
         end
         OP_CHIP_ERASE: begin
            rule_ok = wel & ~any_locked;
            kind    = CYC_CHIP;
         end
         default:                              rule_ok = 1'b0;
      endcase
   end

   assign allow = rule_ok & ~wip;
   assign start = cmd_valid & allow & (op != OP_WEN_SET) & (op != OP_WEN_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_accept   <= 1'b0;
         cmd_abort    <= 1'b0;
         wel          <= 1'b0;
         prot_en      <= 1'b0;
         bp           <= 2'b00;
         pend_sr      <= 1'b0;
         pend_prot_en <= 1'b0;
         pend_bp      <= 2'b00;
      end else begin
         cmd_accept <= cmd_valid & allow;
         cmd_abort  <= cmd_valid & ~allow;
         if (cmd_valid && allow) begin
            if (op == OP_WEN_SET) wel <= 1'b1;
            if (op == OP_WEN_CLR) wel <= 1'b0;
            if (op == OP_SR_WRITE) begin
               pend_sr      <= 1'b1;
               pend_prot_en <= cmd_wdata[SR_PROT_EN];
               pend_bp      <= cmd_wdata[SR_BP_HI:SR_BP_LO];
            end
         end
         if (done) begin
            wel <= 1'b0;
            if (pend_sr) begin
               prot_en <= pend_prot_en;
               bp      <= pend_bp;
               pend_sr <= 1'b0;
            end
         end
      end
   end

   assign status_byte = {prot_en, 3'b000, bp, wel, wip};

   // R11: one response per strobe, none otherwise
   a_r11_one_response: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (cmd_accept ^ cmd_abort));
   a_r11_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !(cmd_accept || cmd_abort));
   // R9: busy refuses everything
   a_r9_busy_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && wip) |=> cmd_abort);
   // R3: modifying commands need the latch
   a_r3_need_wel: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op >= 3'd2 && !wel) |=> cmd_abort);
   // R4: locked status register
   a_r4_sr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd2 && prot_en && !wp_pin) |=> cmd_abort);
   // R6: chip erase blocked by any protect bit
   a_r6_chip_bp: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd6 && bp != 2'b00) |=> cmd_abort);
   // R8: latch is clear once a cycle has ended
   a_r8_wel_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> !wel);
   // R10: protection bits hold still inside a running cycle
   a_r10_sr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && $past(wip)) |-> $stable({prot_en, bp}));
endmodule

// File: tb/test_nvm_status_guard.sv
module test_nvm_status_guard;
   localparam int ADDR_W  = 17;
   localparam int T_WRITE = 4;
   localparam int T_SECT  = 6;
   localparam int T_CHIP  = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [2:0]        cmd_op = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [7:0]        cmd_wdata = '0;
   logic              wp_pin = 1'b1;
   logic [7:0]        status_byte;
   logic              cmd_accept, cmd_abort, wip;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   bit    exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   nvm_status_guard #(.ADDR_W(ADDR_W), .T_WRITE(T_WRITE), .T_SECT(T_SECT), .T_CHIP(T_CHIP))
   i_nvm_status_guard (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_pin(wp_pin),
      .status_byte(status_byte), .cmd_accept(cmd_accept), .cmd_abort(cmd_abort), .wip(wip)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected response per observed response (R11)
   always @(negedge clk) begin
      if (rst_n && (cmd_accept || cmd_abort)) begin
         if (exp_q.size() == 0) begin
            chk(0, "R11 unexpected response", {cmd_accept, cmd_abort}, 0);
         end else begin
            automatic bit    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(cmd_accept == e && cmd_abort == !e, t, {cmd_accept, cmd_abort}, {e, !e});
         end
      end
   end

   task automatic issue(input int op, input int addr, input int data,
                        input bit exp_acc, input string tag);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 3'(op);
      cmd_addr  = ADDR_W'(addr);
      cmd_wdata = 8'(data);
      exp_q.push_back(exp_acc);
      tag_q.push_back(tag);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic sr_is(input int exp, input string tag);
      chk(status_byte == 8'(exp), tag, status_byte, exp);
   endtask

   task automatic wait_idle(input int exp_len, input string tag);
      automatic int n = 0;
      while (wip) begin
         n++;
         @(negedge clk);
      end
      if (exp_len > 0) chk(n == exp_len, tag, n, exp_len);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      sr_is(8'h00, "R1 reset status");
      rst_n = 1'b1;
      @(negedge clk);
      sr_is(8'h00, "R1 status after reset release");

      issue(3, 0, 0, 0, "R3 program without latch");
      sr_is(8'h00, "R3 no change");
      issue(0, 0, 0, 1, "R2 set latch");
      sr_is(8'h02, "R2 latch set");
      issue(1, 0, 0, 1, "R2 clear latch");
      sr_is(8'h00, "R2 latch cleared");
      issue(0, 0, 0, 1, "R2 set latch");

      issue(2, 0, 8'h84, 1, "R4 status write pin high");
      sr_is(8'h03, "R10 old value during cycle");
      wait_idle(T_WRITE, "R7 status write length");
      sr_is(8'h84, "R8 R10 new value, latch clear");

      issue(0, 0, 0, 1, "R2 set latch");
      issue(3, 'h18000, 0, 0, "R5 top quarter locked");
      sr_is(8'h86, "R8 abort keeps latch");
      issue(3, 'h17FFF, 0, 1, "R5 below top quarter open");
      sr_is(8'h87, "R8 latch held in cycle");
      wait_idle(T_WRITE, "R7 program length");
      sr_is(8'h84, "R8 latch cleared at end");

      issue(0, 0, 0, 1, "R2 set latch");
      issue(4, 'h00100, 0, 1, "R5 page erase open");
      issue(1, 0, 0, 0, "R9 clear during busy");
      sr_is(8'h87, "R9 no effect while busy");
      wait_idle(0, "");
      issue(0, 0, 0, 1, "R2 set latch");
      issue(5, 'h08000, 0, 1, "R5 sector erase open");
      wait_idle(T_SECT, "R7 sector erase length");
      sr_is(8'h84, "R8 after sector erase");

      issue(0, 0, 0, 1, "R2 set latch");
      issue(6, 0, 0, 0, "R6 chip erase with bp 01");
      sr_is(8'h86, "R6 no change");

      wp_pin = 1'b0;
      issue(2, 0, 8'h00, 0, "R4 status locked by pin");
      sr_is(8'h86, "R4 no change");
      issue(1, 0, 0, 1, "R2 clear with pin low");
      sr_is(8'h84, "R2 cleared with pin low");
      issue(0, 0, 0, 1, "R2 set with pin low");
      wp_pin = 1'b1;
      issue(2, 0, 8'h08, 1, "R4 status write unlocked");
      wp_pin = 1'b0;
      sr_is(8'h87, "R10 busy with old value");
      wait_idle(T_WRITE, "R7 status write length");
      sr_is(8'h08, "R10 pin change ignored");

      issue(0, 0, 0, 1, "R2 set latch");
      issue(3, 'h10000, 0, 0, "R5 top half locked");
      issue(3, 'h0FFFF, 0, 1, "R5 lower half open");
      wait_idle(T_WRITE, "R7 program length");
      issue(0, 0, 0, 1, "R2 set latch");
      issue(4, 'h1FF00, 0, 0, "R5 page in top half locked");
      sr_is(8'h0A, "R5 no change");

      issue(2, 0, 8'h7C, 1, "R4 protect-enable clear, pin low");
      wait_idle(T_WRITE, "R7 status write length");
      sr_is(8'h0C, "R1 unused bits read zero");
      issue(0, 0, 0, 1, "R2 set latch");
      issue(3, 0, 0, 0, "R5 all locked");
      sr_is(8'h0E, "R5 no change");

      issue(2, 0, 8'h00, 1, "R4 clear protection");
      wait_idle(T_WRITE, "R7 status write length");
      issue(0, 0, 0, 1, "R2 set latch");
      issue(6, 'h1234, 0, 1, "R6 chip erase with bp 00");
      wait_idle(T_CHIP, "R7 chip erase length");
      sr_is(8'h00, "R8 after chip erase");

      @(negedge clk);
      chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 0);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule